// File: doc/BRIEF.md
# Signed 16x16 Multiply Unit

This block is the multiply step of a small 16-bit processor's execution stage. It takes a register operand and a source operand, treats both as signed two's complement words, and forms their full 32-bit product one multiplier bit per clock. When the multiply finishes, it presents the result as register-file write requests. The addressing of those requests follows a register-pair rule. An even destination number receives the high product word, and the next odd register receives the low word. An odd destination number receives only the low word, and the high word is dropped.

Condition codes are produced along with the result. N is the sign of the full product and Z marks a product of zero. V is always cleared. C marks a product that cannot be held in a single signed 16-bit word. The issuing stage supplies the seven-bit opcode field and the three-bit register field of the instruction word, together with both operand values and a start strobe. It then waits for the done pulse. Operand fetch through addressing modes and the register file itself lie outside this block.

Top module: `smul16_unit`

## Requirements
- R1: A start pulse is accepted when the unit is idle and `op_code` equals binary 0111000. On an accepted pulse, `busy` is high in the following cycle.
- R2: A start pulse with any other `op_code` value is ignored. `busy` and `done` stay low, and no write enable rises.
- R3: `done` rises on the 16th rising clock edge after the accepting edge and stays high for exactly one cycle. `busy` stays high up to and including the done cycle and is low in the cycle after it.
- R4: The result words equal the signed 32-bit product of `reg_val` and `src_val`. The upper 16 bits appear on `hi_data` and the lower 16 bits on `lo_data`.
- R5: For an even `reg_num` r, the done cycle writes `hi_data` to register r and `lo_data` to register r+1. Both `hi_we` and `lo_we` are high in that cycle.
- R6: For an odd `reg_num` r, the done cycle writes `lo_data` to register r and `hi_we` stays low.
- R7: `flag_n` equals bit 31 of the product and `flag_z` is set only when all 32 product bits are zero. `flag_v` is zero after every multiply.
- R8: `flag_c` is set exactly when the product lies outside -32768..32767. For example, 181*181 leaves it clear and 181*182 sets it.
- R9: The write enables are high only in the done cycle. The flags and data outputs change only on the edge that starts the done cycle and hold their values until the next done cycle.
- R10: Start pulses and changes to the operand, opcode or register inputs while `busy` is high are ignored. The result uses the values captured on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Issue strobe, one cycle |
| op_code | input | 7 | Opcode field of the instruction word |
| reg_num | input | 3 | Register field of the instruction word |
| reg_val | input | 16 | Contents of the selected register (multiplicand) |
| src_val | input | 16 | Source operand value (multiplier) |
| busy | output | 1 | High from the cycle after acceptance through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| hi_we | output | 1 | Write enable for the high product word |
| hi_addr | output | 3 | Register number for the high word |
| hi_data | output | 16 | High product word |
| lo_we | output | 1 | Write enable for the low product word |
| lo_addr | output | 3 | Register number for the low word |
| lo_data | output | 16 | Low product word |
| flag_n | output | 1 | Negative condition code |
| flag_z | output | 1 | Zero condition code |
| flag_v | output | 1 | Overflow condition code (always cleared) |
| flag_c | output | 1 | Product exceeds signed 16-bit range |

## Verification
Faults in the iteration counter or the state register show up at the ports as a done pulse arriving on the wrong edge, or a unit that stays busy. Either is visible within about 17 cycles of an accepted start. A fault in the accumulator or the multiplier shift register does not stay hidden until some later operation. It shows in the same done cycle as a wrong product word, sign flag or range flag. Operand pairs are chosen to expose sign-handling faults: both signs, the most negative value, and products just inside and just outside the 16-bit range. Failures to capture or hold inputs are provoked by changing the inputs and pulsing start mid-operation.

// File: rtl/smul_pkg.sv
package smul_pkg;

   // instruction word layout: opcode | register | source specifier
   localparam int INSN_W      = 16;
   localparam int SRC_FIELD_W = 6;
   localparam int REG_FIELD_W = 3;
   localparam int OPC_FIELD_W = INSN_W - REG_FIELD_W - SRC_FIELD_W;

   localparam logic [OPC_FIELD_W-1:0] MUL_OPCODE = 7'b0111000;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } smul_state_e;

   function automatic logic is_mul_op(input logic [OPC_FIELD_W-1:0] opc);
      return opc == MUL_OPCODE;
   endfunction

endpackage

// File: rtl/smul_decode.sv
module smul_decode
   import smul_pkg::*;
(
   input  logic                   start,
   input  logic                   idle,
   input  logic [OPC_FIELD_W-1:0] op_code,
   output logic                   accept
);

   assign accept = start & idle & is_mul_op(op_code);

endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
   import smul_pkg::*;
#(
   parameter int STEPS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   output logic idle,
   output logic busy,
   output logic step,
   output logic last,
   output logic done
);

   localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEPS - 1);

   smul_state_e      st_q, st_d;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (accept) st_d = ST_RUN;
         ST_RUN:  if (cnt_q == LAST_CNT) st_d = ST_DONE;
         ST_DONE: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         st_q <= st_d;
         if (accept)
            cnt_q <= '0;
         else if (st_q == ST_RUN)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign idle = (st_q == ST_IDLE);
   assign busy = !idle;
   assign step = (st_q == ST_RUN);
   assign last = step && (cnt_q == LAST_CNT);
   assign done = (st_q == ST_DONE);

   // R1: an accepted start makes the unit busy on the next cycle
   a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy);

   // R3: done lasts one cycle and the unit is idle right after it
   a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R3: the final iteration is followed by the done cycle
   a_r3_last_to_done: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> done);

endmodule

// File: rtl/smul_iter.sv
module smul_iter #(
   parameter int DATA_W    = 16,
   parameter bit USE_BOOTH = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic                  step,
   input  logic                  last,
   input  logic [DATA_W-1:0]     mcand,
   input  logic [DATA_W-1:0]     mplier,
   output logic [2*DATA_W-1:0]   prod_nx
);

   localparam int ACC_W = DATA_W + 2;

   logic [DATA_W-1:0]       mc_q;
   logic [DATA_W-1:0]       lo_q;
   logic [DATA_W:0]         hi_q;
   logic signed [ACC_W-1:0] mc_x;
   logic signed [ACC_W-1:0] addend;
   logic signed [ACC_W-1:0] sum;
   logic [DATA_W-1:0]       lo_nx;

   assign mc_x = {{2{mc_q[DATA_W-1]}}, mc_q};

   generate
      if (USE_BOOTH) begin : g_booth
         logic qm1_q;
         logic unused_last;
         assign unused_last = last;

         always_comb begin
            unique case ({lo_q[0], qm1_q})
               2'b01:   addend = mc_x;
               2'b10:   addend = -mc_x;
               default: addend = '0;
            endcase
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               qm1_q <= 1'b0;
            else if (load)
               qm1_q <= 1'b0;
            else if (step)
               qm1_q <= lo_q[0];
         end
      end else begin : g_shift_add
         // the sign bit of the multiplier carries negative weight
         always_comb begin
            if (lo_q[0])
               addend = last ? -mc_x : mc_x;
            else
               addend = '0;
         end
      end
   endgenerate

   assign sum     = {hi_q[DATA_W], hi_q} + addend;
   assign lo_nx   = {sum[0], lo_q[DATA_W-1:1]};
   assign prod_nx = {sum[DATA_W:1], lo_nx};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mc_q <= '0;
         lo_q <= '0;
         hi_q <= '0;
      end else if (load) begin
         mc_q <= mcand;
         lo_q <= mplier;
         hi_q <= '0;
      end else if (step) begin
         hi_q <= sum[ACC_W-1:1];
         lo_q <= lo_nx;
      end
   end

   // R10: captured multiplicand does not move while iterating
   a_r10_mcand_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && $past(step)) |-> $stable(mc_q));

endmodule

// File: rtl/smul_result.sv
module smul_result #(
   parameter int DATA_W = 16,
   parameter int REG_AW = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 capture,
   input  logic [REG_AW-1:0]    dst,
   input  logic [2*DATA_W-1:0]  prod,
   output logic                 hi_we,
   output logic [REG_AW-1:0]    hi_addr,
   output logic [DATA_W-1:0]    hi_data,
   output logic                 lo_we,
   output logic [REG_AW-1:0]    lo_addr,
   output logic [DATA_W-1:0]    lo_data,
   output logic                 flag_n,
   output logic                 flag_z,
   output logic                 flag_v,
   output logic                 flag_c
);

   logic [DATA_W:0] top_bits;
   logic            out_of_range;

   // product fits in one word only if bits 2W-1..W-1 all agree
   assign top_bits     = prod[2*DATA_W-1:DATA_W-1];
   assign out_of_range = (|top_bits) & ~(&top_bits);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_we   <= 1'b0;
         lo_we   <= 1'b0;
         hi_addr <= '0;
         lo_addr <= '0;
         hi_data <= '0;
         lo_data <= '0;
         flag_n  <= 1'b0;
         flag_z  <= 1'b0;
         flag_v  <= 1'b0;
         flag_c  <= 1'b0;
      end else begin
         hi_we <= 1'b0;
         lo_we <= 1'b0;
         if (capture) begin
            hi_we   <= ~dst[0];
            lo_we   <= 1'b1;
            hi_addr <= dst;
            lo_addr <= {dst[REG_AW-1:1], 1'b1};
            hi_data <= prod[2*DATA_W-1:DATA_W];
            lo_data <= prod[DATA_W-1:0];
            flag_n  <= prod[2*DATA_W-1];
            flag_z  <= (prod == '0);
            flag_v  <= 1'b0;
            flag_c  <= out_of_range;
         end
      end
   end

   // R5: a pair write targets an even register and its odd partner
   a_r5_pair_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
      hi_we |-> (lo_we && !hi_addr[0] && (lo_addr == hi_addr + 1'b1)));

   // R9: flags hold between completions
   a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(capture) |-> $stable({flag_n, flag_z, flag_v, flag_c}));

endmodule

// File: rtl/smul16_unit.sv
module smul16_unit
   import smul_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter bit USE_BOOTH = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [OPC_FIELD_W-1:0] op_code,
   input  logic [REG_FIELD_W-1:0] reg_num,
   input  logic [DATA_W-1:0]      reg_val,
   input  logic [DATA_W-1:0]      src_val,
   output logic                   busy,
   output logic                   done,
   output logic                   hi_we,
   output logic [REG_FIELD_W-1:0] hi_addr,
   output logic [DATA_W-1:0]      hi_data,
   output logic                   lo_we,
   output logic [REG_FIELD_W-1:0] lo_addr,
   output logic [DATA_W-1:0]      lo_data,
   output logic                   flag_n,
   output logic                   flag_z,
   output logic                   flag_v,
   output logic                   flag_c
);

   localparam int STEPS = DATA_W;

   generate
      if (DATA_W < 4)
         $error("smul16_unit: DATA_W must be at least 4");
      if (REG_FIELD_W < 2)
         $error("smul16_unit: register field too narrow for pairs");
   endgenerate

   logic                   idle, accept, step, last;
   logic [REG_FIELD_W-1:0] dst_q;
   logic [2*DATA_W-1:0]    prod_nx;

   smul_decode u_decode (
      .start   (start),
      .idle    (idle),
      .op_code (op_code),
      .accept  (accept)
   );

   smul_ctrl #(.STEPS(STEPS)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept),
      .idle   (idle),
      .busy   (busy),
      .step   (step),
      .last   (last),
      .done   (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dst_q <= '0;
      else if (accept)
         dst_q <= reg_num;
   end

   smul_iter #(.DATA_W(DATA_W), .USE_BOOTH(USE_BOOTH)) u_iter (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .step    (step),
      .last    (last),
      .mcand   (reg_val),
      .mplier  (src_val),
      .prod_nx (prod_nx)
   );

   smul_result #(.DATA_W(DATA_W), .REG_AW(REG_FIELD_W)) u_result (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (last),
      .dst     (dst_q),
      .prod    (prod_nx),
      .hi_we   (hi_we),
      .hi_addr (hi_addr),
      .hi_data (hi_data),
      .lo_we   (lo_we),
      .lo_addr (lo_addr),
      .lo_data (lo_data),
      .flag_n  (flag_n),
      .flag_z  (flag_z),
      .flag_v  (flag_v),
      .flag_c  (flag_c)
   );

   // R2: a start with a foreign opcode leaves the unit idle
   a_r2_foreign_op: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !is_mul_op(op_code)) |=> !busy);

   // R9: write requests only in the done cycle
   a_r9_we_in_done: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_we || lo_we) |-> done);

   // R7: sign flag agrees with the high result word
   a_r7_sign_matches: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flag_n == hi_data[DATA_W-1]));

   // R7: zero flag implies both words are zero
   a_r7_zero_words: assert property (@(posedge clk) disable iff (!rst_n)
      (done && flag_z) |-> (hi_data == '0 && lo_data == '0));

endmodule

// File: tb/smul16_unit_tb.sv
module smul16_unit_tb;

   localparam int CLK_PERIOD = 10;
   localparam logic [6:0] OPC_MUL = 7'b0111000;

   typedef struct packed {
      logic [2:0]  r;
      logic [15:0] hi;
      logic [15:0] lo;
      logic        n;
      logic        z;
      logic        c;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [6:0]  op_code = '0;
   logic [2:0]  reg_num = '0;
   logic [15:0] reg_val = '0;
   logic [15:0] src_val = '0;
   logic        busy, done, hi_we, lo_we;
   logic [2:0]  hi_addr, lo_addr;
   logic [15:0] hi_data, lo_data;
   logic        flag_n, flag_z, flag_v, flag_c;

   int   n_checks = 0;
   int   n_fails  = 0;
   bit   reported = 1'b0;
   exp_t sb_q[$];
   exp_t mon_e;

   always #(CLK_PERIOD/2) clk = ~clk;

   smul16_unit u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
      .reg_num(reg_num), .reg_val(reg_val), .src_val(src_val),
      .busy(busy), .done(done), .hi_we(hi_we), .hi_addr(hi_addr),
      .hi_data(hi_data), .lo_we(lo_we), .lo_addr(lo_addr),
      .lo_data(lo_data), .flag_n(flag_n), .flag_z(flag_z),
      .flag_v(flag_v), .flag_c(flag_c)
   );

   task automatic chk(input string req, input longint act, input longint exp,
                      input string what);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      end
   endtask

   // monitor: compares every completion against the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            if (sb_q.size() == 0) begin
               chk("R9", 1, 0, "done without pending operation");
            end else begin
               mon_e = sb_q.pop_front();
               chk("R4", lo_data, mon_e.lo, "low product word");
               chk("R7", flag_n, mon_e.n, "N flag");
               chk("R7", flag_z, mon_e.z, "Z flag");
               chk("R7", flag_v, 0, "V flag");
               chk("R8", flag_c, mon_e.c, "C flag");
               chk("R5", lo_we, 1, "low word write enable");
               if (!mon_e.r[0]) begin
                  chk("R5", hi_we, 1, "high write enable even reg");
                  chk("R5", hi_addr, mon_e.r, "high word register");
                  chk("R5", lo_addr, mon_e.r + 3'd1, "low word register");
                  chk("R4", hi_data, mon_e.hi, "high product word");
               end else begin
                  chk("R6", hi_we, 0, "high write enable odd reg");
                  chk("R6", lo_addr, mon_e.r, "low word register odd");
               end
            end
         end else if (hi_we || lo_we) begin
            chk("R9", {hi_we, lo_we}, 0, "write enable outside done");
         end
      end
   end

   task automatic run_op(input logic signed [15:0] a, input logic signed [15:0] b,
                         input logic [2:0] r, input bit disturb);
      longint p;
      exp_t   e;
      int     k;
      p    = longint'(a) * longint'(b);
      e.r  = r;
      e.hi = p[31:16];
      e.lo = p[15:0];
      e.n  = p[31];
      e.z  = (p == 0);
      e.c  = (p > 32767) || (p < -32768);
      sb_q.push_back(e);
      @(negedge clk);
      op_code = OPC_MUL; reg_num = r; reg_val = a; src_val = b; start = 1'b1;
      @(negedge clk);
      k = 1;
      start = 1'b0;
      chk("R1", busy, 1, "busy after accepted start");
      if (disturb) begin
         // R10: new start and operand changes while busy
         start = 1'b1; reg_val = ~a; src_val = b + 16'd3; reg_num = r ^ 3'd1;
      end
      while (!done && k < 40) begin
         @(negedge clk);
         k++;
         start = 1'b0;
      end
      chk("R3", k - 1, 16, "edges from accept to done");
      @(negedge clk);
      chk("R3", {busy, done}, 0, "busy and done after done cycle");
      chk("R9", {hi_we, lo_we}, 0, "enables after done cycle");
      chk("R9", {flag_n, flag_z, flag_c}, {e.n, e.z, e.c}, "flags hold");
      if (disturb)
         chk("R10", {busy, done}, 0, "mid-run start not accepted");
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++;
      n_fails++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R9", {busy, done, hi_we, lo_we}, 0, "reset handshake state");
      chk("R7", {flag_n, flag_z, flag_v, flag_c}, 0, "reset flags");
      rst_n = 1'b1;
      @(negedge clk);

      // R2: foreign opcode is ignored
      op_code = 7'b0111001; reg_num = 3'd2; reg_val = 16'd5; src_val = 16'd7;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      begin
         bit seen = 1'b0;
         for (int i = 0; i < 20; i++) begin
            if (busy || done || hi_we || lo_we) seen = 1'b1;
            @(negedge clk);
         end
         chk("R2", seen, 0, "activity after foreign opcode");
      end

      run_op(16'sd0,      16'sd0,      3'd0, 1'b0);
      run_op(16'sd1,      -16'sd1,     3'd1, 1'b0);
      run_op(-16'sd1,     -16'sd1,     3'd2, 1'b0);
      run_op(16'sd181,    16'sd181,    3'd3, 1'b0);
      run_op(16'sd181,    16'sd182,    3'd4, 1'b0);
      run_op(16'sd181,    -16'sd182,   3'd5, 1'b0);
      run_op(16'sd31022,  16'sd9562,   3'd6, 1'b1);
      run_op(16'sd18494,  -16'sd24041, 3'd0, 1'b1);
      run_op(-16'sd12549, 16'sd2397,   3'd7, 1'b0);
      run_op(-16'sd20493, -16'sd23858, 3'd2, 1'b0);
      run_op(-16'sd32768, -16'sd32768, 3'd4, 1'b0);
      run_op(-16'sd32768, 16'sd1,      3'd6, 1'b0);
      run_op(16'sd32767,  -16'sd32768, 3'd1, 1'b1);
      run_op(-16'sd1,     16'sd0,      3'd3, 1'b0);

      chk("R4", sb_q.size(), 0, "all operations completed");
      report();
      $finish;
   end

endmodule